// File: doc/BRIEF.md
# Snooping MSI Cache Coherence Controller

This block is the coherence engine of one private cache on a shared-bus multiprocessor. It owns a small direct-mapped array of one-word lines. Each line carries a tag, a data word and one of three coherence states: Invalid, Shared or Modified. Processor loads and stores are served from the array whenever the line's state grants the needed permission. Otherwise the controller stalls the processor and requests the bus for a read, a read-for-ownership write, a dataless upgrade or a writeback of a dirty victim.

At the same time the controller watches the transactions that other caches place on the bus. When another cache reads a line held here as Modified, this cache drives the data and raises a "supplied by cache" flag, and it drops to Shared. Memory captures the same word in that cycle. When another cache writes a line or upgrades it, the local copy is invalidated, and a Modified copy hands over its data first.

Bus transactions take one cycle. A transaction completes in the cycle where `busReq` and `busGrant` are both high. Response data on `busRdata` is valid in that cycle. An external arbiter never grants this cache in a cycle where it presents a snoop on `snpValid`.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address requests the bus.
- R2: A read that misses raises `busReq` with command read (`busCmd` = 1) and the request address. In the grant cycle `cpuReady` rises and `cpuRdata` equals `busRdata`. The line is then held Shared.
- R3: A read of a Shared or Modified line, or a write of a Modified line, raises `cpuReady` in the request cycle without `busReq`. A read returns the stored word.
- R4: A write to a Shared line issues upgrade (`busCmd` = 3) and no data is taken from the bus. When granted, the line becomes Modified and holds the written word.
- R5: A write to an absent line issues write (`busCmd` = 2). When granted, the line is installed Modified with the processor's word.
- R6: A miss whose index holds a different Modified line first issues writeback (`busCmd` = 4). The writeback carries the victim's address and data. The miss request follows only after that grant.
- R7: While a needed transaction is not granted, `busReq` stays high and `cpuReady` stays low.
- R8: A snooped read (`snpCmd` = 1) of a Modified line raises `snpSupply` and drives the line's data on `snpData`. The line becomes Shared, so a later local write needs an upgrade.
- R9: A snooped read of a Shared line, or a snooped writeback (`snpCmd` = 4), leaves `snpSupply` low and keeps the line readable.
- R10: A snooped write (`snpCmd` = 2) invalidates the matching line. If that line was Modified, its data is supplied in the same cycle.
- R11: A snooped upgrade (`snpCmd` = 3) invalidates a matching Shared line without supplying data.
- R12: When a snoop and a processor request name the same index in one cycle, the processor request neither completes nor requests the bus in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until `cpuReady` |
| cpuWrite | input | 1 | 1 for store, 0 for load |
| cpuAddr | input | AW | Word address of the request |
| cpuWdata | input | DW | Store data |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | DW | Load data, valid with `cpuReady` |
| busReq | output | 1 | Transaction wanted |
| busGrant | input | 1 | Transaction takes place this cycle |
| busCmd | output | 3 | 0 none, 1 read, 2 write, 3 upgrade, 4 writeback |
| busAddr | output | AW | Transaction address |
| busWdata | output | DW | Writeback data |
| busRdata | input | DW | Response data in the grant cycle |
| snpValid | input | 1 | Another cache's transaction is on the bus |
| snpCmd | input | 3 | Its command, same encoding as `busCmd` |
| snpAddr | input | AW | Its address |
| snpSupply | output | 1 | This cache supplies the data |
| snpData | output | DW | Supplied data |

## Verification
Two situations are hard to reach from the ports. The first is a snoop that lands on the index of a processor request which is still pending. The second is a miss that must first evict a dirty line. The stimulus draws each address from only three tags per index, which makes conflicting misses on Modified lines frequent. Some processor requests carry a flag that presents a random snoop on the same index in their first cycle. A directed opening walks one address through upgrade, supply-and-downgrade, invalidation and writeback. After that, a long random mix of loads, stores and legal snoops runs with random grant delays. Every step is checked against a reference model of the line states kept in the bench.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LINE_INV = 2'b00,
    LINE_SHR = 2'b01,
    LINE_MOD = 2'b10
  } lineState_e;

  typedef enum logic [2:0] {
    BUS_IDLE  = 3'd0,
    BUS_READ  = 3'd1,
    BUS_WRITE = 3'd2,
    BUS_UPGR  = 3'd3,
    BUS_WBACK = 3'd4
  } busCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cpuWr;    // store hit on a Modified line
    logic fill;     // install the granted line at the request index
    logic fillMod;  // installed line becomes Modified (else Shared)
    logic evict;    // writeback granted: victim becomes Invalid
    logic snpDown;  // snooped line Modified -> Shared
    logic snpInv;   // snooped line -> Invalid
  } dpStrobe_t;

endpackage

// File: rtl/msi_datapath.sv
module msi_datapath
  import msi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [AW-1:0]    cpuAddr,
  input  logic [DW-1:0]    cpuWdata,
  input  logic [DW-1:0]    busRdata,
  input  logic [AW-1:0]    snpAddr,
  output lineState_e       cpuState,
  output logic             victimDirty,
  output logic [AW-1:0]    victimAddr,
  output logic [DW-1:0]    lineData,
  output lineState_e       snpState,
  output logic [DW-1:0]    snpLineData,
  output logic             sameIdx
);

  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = AW - IDX_W;

  lineState_e       stQ   [LINES];
  logic [TAG_W-1:0] tagQ  [LINES];
  logic [DW-1:0]    dataQ [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  logic             cpuMatch, snpMatch;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[AW-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[AW-1:IDX_W];

  assign cpuMatch    = (tagQ[cpuIdx] == cpuTag);
  assign snpMatch    = (tagQ[snpIdx] == snpTag);
  assign cpuState    = cpuMatch ? stQ[cpuIdx] : LINE_INV;
  assign snpState    = snpMatch ? stQ[snpIdx] : LINE_INV;
  assign victimDirty = !cpuMatch && (stQ[cpuIdx] == LINE_MOD);
  assign victimAddr  = {tagQ[cpuIdx], cpuIdx};
  assign lineData    = dataQ[cpuIdx];
  assign snpLineData = dataQ[snpIdx];
  assign sameIdx     = (cpuIdx == snpIdx);

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (!rstN) begin
        stQ[i]   <= LINE_INV;
        tagQ[i]  <= '0;
        dataQ[i] <= '0;
      end else begin
        if (cpuIdx == IDX_W'(i)) begin
          if (stb.evict) begin
            stQ[i] <= LINE_INV;
          end else if (stb.fill) begin
            tagQ[i]  <= cpuTag;
            stQ[i]   <= stb.fillMod ? LINE_MOD : LINE_SHR;
            dataQ[i] <= stb.fillMod ? cpuWdata : busRdata;
          end else if (stb.cpuWr) begin
            dataQ[i] <= cpuWdata;
          end
        end
        if (snpIdx == IDX_W'(i)) begin
          if (stb.snpInv)       stQ[i] <= LINE_INV;
          else if (stb.snpDown) stQ[i] <= LINE_SHR;
        end
      end
    end
  end

endmodule

// File: rtl/msi_control.sv
module msi_control
  import msi_pkg::*;
(
  input  logic       cpuReq,
  input  logic       cpuWrite,
  input  lineState_e cpuState,
  input  logic       victimDirty,
  input  logic       busGrant,
  input  logic       snpValid,
  input  logic [2:0] snpCmd,
  input  lineState_e snpState,
  input  logic       sameIdx,
  output dpStrobe_t  stb,
  output logic       busReq,
  output busCmd_e    busCmd,
  output logic       cpuReady,
  output logic       rdFromBus,
  output logic       snpSupply
);

  logic    cpuBlocked, hitOk, needBus, granted, snpHit;
  busCmd_e cmdSel;

  always_comb begin
    snpHit     = snpValid && (snpState != LINE_INV);
    cpuBlocked = snpValid && sameIdx;
    hitOk      = cpuReq && !cpuBlocked &&
                 ((cpuState == LINE_MOD) || (cpuState == LINE_SHR && !cpuWrite));
    needBus    = cpuReq && !cpuBlocked && !hitOk;

    if (victimDirty)               cmdSel = BUS_WBACK;
    else if (!cpuWrite)            cmdSel = BUS_READ;
    else if (cpuState == LINE_SHR) cmdSel = BUS_UPGR;
    else                           cmdSel = BUS_WRITE;

    busReq  = needBus;
    busCmd  = needBus ? cmdSel : BUS_IDLE;
    granted = needBus && busGrant;

    stb.evict   = granted && (cmdSel == BUS_WBACK);
    stb.fill    = granted && (cmdSel != BUS_WBACK);
    stb.fillMod = cpuWrite;
    stb.cpuWr   = hitOk && cpuWrite;
    stb.snpDown = snpValid && (snpState == LINE_MOD) && (snpCmd == BUS_READ);
    stb.snpInv  = snpHit && ((snpCmd == BUS_WRITE) || (snpCmd == BUS_UPGR));

    snpSupply = snpValid && (snpState == LINE_MOD) &&
                ((snpCmd == BUS_READ) || (snpCmd == BUS_WRITE));
    cpuReady  = hitOk || stb.fill;
    rdFromBus = stb.fill;
  end

endmodule

// File: rtl/msi_snoop_cache.sv
module msi_snoop_cache
  import msi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int IDX_W = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuReq,
  input  logic          cpuWrite,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  output logic          cpuReady,
  output logic [DW-1:0] cpuRdata,
  output logic          busReq,
  input  logic          busGrant,
  output logic [2:0]    busCmd,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  input  logic [DW-1:0] busRdata,
  input  logic          snpValid,
  input  logic [2:0]    snpCmd,
  input  logic [AW-1:0] snpAddr,
  output logic          snpSupply,
  output logic [DW-1:0] snpData
);

  dpStrobe_t     stb;
  lineState_e    cpuState, snpState;
  busCmd_e       cmdOut;
  logic          victimDirty, sameIdx, rdFromBus;
  logic [AW-1:0] victimAddr;
  logic [DW-1:0] lineData, snpLineData;

  msi_datapath #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) dp_i (
    .clk, .rstN, .stb, .cpuAddr, .cpuWdata, .busRdata, .snpAddr,
    .cpuState, .victimDirty, .victimAddr, .lineData,
    .snpState, .snpLineData, .sameIdx
  );

  msi_control ctl_i (
    .cpuReq, .cpuWrite, .cpuState, .victimDirty, .busGrant,
    .snpValid, .snpCmd, .snpState, .sameIdx,
    .stb, .busReq, .busCmd(cmdOut), .cpuReady, .rdFromBus, .snpSupply
  );

  assign busCmd   = cmdOut;
  assign busAddr  = (cmdOut == BUS_WBACK) ? victimAddr : cpuAddr;
  assign busWdata = (cmdOut == BUS_WBACK) ? lineData : '0;
  assign cpuRdata = rdFromBus ? busRdata : lineData;
  assign snpData  = snpSupply ? snpLineData : '0;

endmodule

// File: rtl/msi_snoop_cache_chk.sv
module msi_snoop_cache_chk
  import msi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int IDX_W = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuReq,
  input logic          cpuWrite,
  input logic [AW-1:0] cpuAddr,
  input logic          cpuReady,
  input logic          busReq,
  input logic          busGrant,
  input logic [2:0]    busCmd,
  input logic [AW-1:0] busAddr,
  input logic          snpValid,
  input logic [2:0]    snpCmd,
  input logic [AW-1:0] snpAddr,
  input logic          snpSupply
);

  assert_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busCmd != BUS_IDLE));

  assert_upgrade_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busCmd == BUS_UPGR) |-> cpuWrite);

  assert_wback_once_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGrant && busCmd == BUS_WBACK) |=>
      !(busReq && busCmd == BUS_WBACK && busAddr == $past(busAddr)));

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGrant) |-> !cpuReady);

  assert_supply_R8: assert property (@(posedge clk) disable iff (!rstN)
    snpSupply |-> (snpValid && (snpCmd == BUS_READ || snpCmd == BUS_WRITE)));

  assert_inval_R10: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpCmd == BUS_WRITE && snpSupply) |=>
      !(snpValid && snpAddr == $past(snpAddr) && snpSupply));

  assert_collide_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && snpValid && cpuAddr[IDX_W-1:0] == snpAddr[IDX_W-1:0]) |->
      (!cpuReady && !busReq));

endmodule

bind msi_snoop_cache msi_snoop_cache_chk #(.AW(AW), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
  .cpuAddr(cpuAddr), .cpuReady(cpuReady), .busReq(busReq),
  .busGrant(busGrant), .busCmd(busCmd), .busAddr(busAddr),
  .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
  .snpSupply(snpSupply)
);

// File: tb/msi_snoop_cache_tb.sv
`timescale 1ns/1ps
module msi_snoop_cache_tb_top;
  localparam int AW = 8, DW = 8, IW = 2, LINES = 4;

  logic clk = 0, rstN = 0;
  logic cpuReq = 0, cpuWrite = 0, cpuReady;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0, cpuRdata;
  logic busReq, busGrant = 0;
  logic [2:0] busCmd;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata, busRdata = '0;
  logic snpValid = 0, snpSupply;
  logic [2:0] snpCmd = '0;
  logic [AW-1:0] snpAddr = '0;
  logic [DW-1:0] snpData;

  msi_snoop_cache #(.AW(AW), .DW(DW), .IDX_W(IW)) dut_i (.*);

  always #2 clk = ~clk;

  int nChecks = 0, nFails = 0;
  logic [1:0]      mState [LINES];
  logic [AW-IW-1:0] mTag  [LINES];
  logic [DW-1:0]   mData  [LINES];
  logic [DW-1:0]   mem    [256];

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] effState(logic [AW-1:0] a);
    return (mTag[a[IW-1:0]] == a[AW-1:IW]) ? mState[a[IW-1:0]] : 2'd0;
  endfunction

  function automatic bit expHit(bit wr, logic [AW-1:0] a);
    logic [1:0] st = effState(a);
    return (st == 2'd2) || (st == 2'd1 && !wr);
  endfunction

  function automatic logic [2:0] expCmd(bit wr, logic [AW-1:0] a);
    logic [IW-1:0] i = a[IW-1:0];
    if (mState[i] == 2'd2 && mTag[i] != a[AW-1:IW]) return 3'd4;
    if (!wr) return 3'd1;
    if (effState(a) == 2'd1) return 3'd3;
    return 3'd2;
  endfunction

  function automatic logic [2:0] fixCmd(logic [2:0] c, logic [AW-1:0] a);
    if (c == 3'd3 && effState(a) == 2'd2) return 3'd2;
    if (c == 3'd4 && effState(a) != 2'd0) return 3'd1;
    return c;
  endfunction

  // drive a snoop (caller is at a negedge) and check the response
  task automatic snpDrive(logic [2:0] c, logic [AW-1:0] a);
    logic [1:0] st = effState(a);
    bit sup = (st == 2'd2) && (c == 3'd1 || c == 3'd2);
    string tag = (c == 3'd1) ? ((st == 2'd2) ? "R8" : "R9") :
                 (c == 3'd2) ? "R10" : (c == 3'd3) ? "R11" : "R9";
    snpValid = 1; snpCmd = c; snpAddr = a;
    #1;
    chk(tag, snpSupply, sup);
    if (sup) chk(tag, snpData, mData[a[IW-1:0]]);
  endtask

  task automatic snpApply(logic [2:0] c, logic [AW-1:0] a);
    logic [1:0] st = effState(a);
    logic [IW-1:0] i = a[IW-1:0];
    case (c)
      3'd1: if (st == 2'd2) begin mem[a] = mData[i]; mState[i] = 2'd1; end
      3'd2, 3'd3: begin if (st != 2'd0) mState[i] = 2'd0; mem[a] = DW'($urandom); end
      default: mem[a] = DW'($urandom);
    endcase
  endtask

  task automatic doSnoop(logic [2:0] c0, logic [AW-1:0] a);
    logic [2:0] c;
    @(negedge clk);
    cpuReq = 0; busGrant = 0;
    c = fixCmd(c0, a);
    snpDrive(c, a);
    @(posedge clk);
    snpApply(c, a);
  endtask

  task automatic cpuOp(bit wr, logic [AW-1:0] a, logic [DW-1:0] wd, int minStall, bit collide);
    logic [IW-1:0] i = a[IW-1:0];
    logic [2:0] ec, sc;
    logic [AW-1:0] sa, ea;
    int stall = 0;
    bit done = 0, give;
    string tag;
    @(negedge clk);
    snpValid = 0; busGrant = 0;
    cpuReq = 1; cpuWrite = wr; cpuAddr = a; cpuWdata = wd;
    if (collide) begin
      sa = {AW'($urandom_range(0, 2)) << IW} | AW'(i);
      sc = fixCmd(3'($urandom_range(1, 3)), sa);
      snpDrive(sc, sa);
      chk("R12", {cpuReady, busReq}, 0);
      @(posedge clk);
      snpApply(sc, sa);
      @(negedge clk);
      snpValid = 0;
    end
    while (!done) begin
      if (expHit(wr, a)) begin
        #1;
        chk("R3", {cpuReady, busReq}, 2);
        if (!wr) chk("R3", cpuRdata, mData[i]);
        @(posedge clk);
        if (wr) mData[i] = wd;
        done = 1;
      end else begin
        ec = expCmd(wr, a);
        tag = (ec == 3'd1) ? "R2" : (ec == 3'd2) ? "R5" : (ec == 3'd3) ? "R4" : "R6";
        give = !(stall < minStall || ($urandom_range(0, 3) == 0 && stall < 4));
        busGrant = give;
        busRdata = mem[a];
        #1;
        ea = (ec == 3'd4) ? {mTag[i], i} : a;
        chk(tag, busReq, 1);
        chk(tag, busCmd, ec);
        chk(tag, busAddr, ea);
        if (ec == 3'd4) chk("R6", busWdata, mData[i]);
        if (!give) begin
          chk("R7", cpuReady, 0);
          stall++;
          @(posedge clk);
        end else begin
          chk(tag, cpuReady, (ec != 3'd4));
          if (ec == 3'd1) chk("R2", cpuRdata, mem[a]);
          @(posedge clk);
          if (ec == 3'd4) begin
            mem[{mTag[i], i}] = mData[i];
            mState[i] = 2'd0;
            stall = 0;
          end else begin
            mTag[i]   = a[AW-1:IW];
            mState[i] = wr ? 2'd2 : 2'd1;
            mData[i]  = wr ? wd : mem[a];
            done = 1;
          end
        end
        if (!done) begin
          @(negedge clk);
          busGrant = 0;
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [AW-1:0] x, y, ra;
    void'($urandom(32'h1F2E3D4C));
    for (int k = 0; k < 256; k++) mem[k] = DW'(k * 7 + 3);
    for (int k = 0; k < LINES; k++) begin
      mState[k] = 2'd0; mTag[k] = '0; mData[k] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    chk("R1", {cpuReady, busReq, snpSupply}, 0);
    // R1: every line misses after reset
    for (int k = 0; k < LINES; k++) begin
      @(negedge clk);
      cpuReq = 1; cpuWrite = 0; cpuAddr = AW'(k);
      #1;
      chk("R1", {busReq, busCmd}, 4'b1001);
    end
    @(negedge clk);
    cpuReq = 0;

    x = 8'h05; y = 8'h09;
    cpuOp(0, x, 8'h00, 2, 0);   // R2 + R7 stall
    cpuOp(1, x, 8'hAA, 0, 0);   // R4 upgrade
    doSnoop(3'd1, x);           // R8 supply, downgrade
    cpuOp(0, x, 8'h00, 0, 0);   // R3 read hit on Shared
    cpuOp(1, x, 8'hBB, 1, 0);   // R4 again after downgrade
    doSnoop(3'd2, x);           // R10 supply + invalidate
    cpuOp(0, x, 8'h00, 0, 0);   // R2 read miss again
    doSnoop(3'd1, x);           // R9 Shared ignores read
    doSnoop(3'd3, x);           // R11 upgrade invalidates
    cpuOp(1, x, 8'hCC, 0, 0);   // R5 write miss
    cpuOp(1, x, 8'hCD, 0, 0);   // R3 write hit on Modified
    cpuOp(1, y, 8'hDD, 1, 0);   // R6 dirty victim then R5
    cpuOp(0, y, 8'h00, 0, 1);   // R12 collision

    for (int n = 0; n < 600; n++) begin
      ra = {6'($urandom_range(0, 2)), 2'($urandom_range(0, 3))};
      if ($urandom_range(0, 9) < 6)
        cpuOp(bit'($urandom_range(0, 1)), ra, DW'($urandom), 0, ($urandom_range(0, 7) == 0));
      else
        doSnoop(3'($urandom_range(1, 4)), ra);
    end

    @(negedge clk);
    cpuReq = 0; snpValid = 0; busGrant = 0;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule